// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block sits on the controller side of an SDRAM interface and decides when an auto-refresh command is due. A free-running interval timer adds one owed refresh per interval. The interval is the retention window divided by the device's row count, expressed in clock cycles. While any refresh is owed, the block asks the command arbiter for the bus.

Once the bus is granted, the block first closes any open banks with a precharge-all and waits out the row-precharge time. It then issues auto-refresh and keeps the bus silent for the refresh cycle time. Refreshes that were postponed are issued back to back while the grant is held. When nothing is owed, the block drops its request.

No row address is produced, because the device keeps its own refresh row counter. Refresh timing comes from picosecond parameters and a clock-period parameter.

Top module: `refresh_scheduler`

## Requirements
- R1: One refresh becomes owed every INTERVAL cycles, where INTERVAL = floor(WINDOW_PS / ROWS / CLK_PS); with defaults (64 ms, 8192 rows, 8 ns) that is 976 cycles. After reset, `ref_req` is first high in cycle 977.
- R2: The interval follows the row-count parameter: with ROWS = 4096 and all else default, `ref_req` is first high in cycle 1954.
- R3: While a refresh is owed, `ref_req` is high. No command is driven before `ref_gnt` is seen: the command pins stay deselected, meaning CS#, RAS#, CAS# and WE# all high.
- R4: If any bit of `bank_open` is set in the cycle the grant is seen, the next cycle carries a precharge-all. Its encoding is CS#=0, RAS#=0, CAS#=1, WE#=0, and `dram_a10` is high in that cycle only.
- R5: Auto-refresh follows a precharge-all exactly TRP cycles later (3 by default). With all banks idle, it comes in the cycle right after the grant is seen.
- R6: Auto-refresh is encoded CS#=0, RAS#=0, CAS#=0, WE#=1. No precharge is ever issued after a refresh.
- R7: For TRFC-1 cycles after an auto-refresh (TRFC = 10 by default), the command pins stay deselected. `ref_req` is low in the cycle TRFC after the last refresh.
- R8: Up to MAX_OWED (8) owed refreshes are counted, and further ones are dropped. On grant, all owed refreshes are issued spaced exactly TRFC cycles apart, with no precharge between them.
- R9: After synchronous reset, `ref_req` is low, the command pins are deselected, and `dram_a10` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open | input | BANKS | One bit per bank, set while the bank has an open row |
| ref_gnt | input | 1 | Command bus granted to the scheduler |
| ref_req | output | 1 | Scheduler requests the command bus |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a10 | output | 1 | Address bit 10, high for precharge-all |

## Verification
The assertions assume the arbiter keeps `ref_gnt` high from the moment it grants until the scheduler lowers `ref_req`. The scheduler does not re-check the grant during the precharge wait. They also assume the bank status is meaningful in the cycle the grant is first seen. The stimulus raises the grant only while a request is pending and holds it until the request falls. It changes `bank_open` only while the grant is low, and releases the grant in the cycle after the request drops.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PRECH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_CLOSE,
        ST_CLOSE_WAIT,
        ST_REFRESH,
        ST_RECOVER
    } rfs_state_t;

    function automatic int ceil_cycles(longint unsigned ps, longint unsigned clk_ps);
        return int'((ps + clk_ps - 1) / clk_ps);
    endfunction

    function automatic int interval_cycles(longint unsigned window_ps,
                                           longint unsigned rows,
                                           longint unsigned clk_ps);
        return int'(window_ps / rows / clk_ps);
    endfunction

    function automatic int at_least_two(int v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_interval.sv
`timescale 1ns/1ps
module rfs_interval #(
    parameter int PERIOD = 976
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R1
    timer_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rfs_owed.sv
`timescale 1ns/1ps
module rfs_owed #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic add,
    input  logic take,
    output logic owed_nz
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

    logic [OW-1:0] owed;

    assign owed_nz = (owed != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            unique case ({add, take})
                2'b10:   owed <= (owed == CAP) ? owed : owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    // R8
    owed_cap_chk: assert property (@(posedge clk) disable iff (rst)
        owed <= CAP);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> owed_nz);

endmodule

// File: rtl/rfs_fsm.sv
`timescale 1ns/1ps
module rfs_fsm
    import rfs_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int TRP_CYC  = 3,
    parameter int TRFC_CYC = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             owed_nz,
    input  logic             gnt,
    input  logic [BANKS-1:0] bank_open,
    output logic             req,
    output dram_cmd_t        cmd,
    output logic             a10,
    output logic             issue
);
    localparam int WW = $clog2(max_int(TRP_CYC, TRFC_CYC));
    localparam logic [WW-1:0] TRP_LOAD  = WW'(TRP_CYC - 2);
    localparam logic [WW-1:0] TRFC_LOAD = WW'(TRFC_CYC - 2);

    rfs_state_t st, st_n;
    logic [WW-1:0] wcnt, wcnt_n;

    always_comb begin
        st_n   = st;
        wcnt_n = wcnt;
        unique case (st)
            ST_IDLE: if (owed_nz) st_n = ST_ASK;
            ST_ASK: begin
                if (gnt) st_n = (|bank_open) ? ST_CLOSE : ST_REFRESH;
            end
            ST_CLOSE: begin
                st_n   = ST_CLOSE_WAIT;
                wcnt_n = TRP_LOAD;
            end
            ST_CLOSE_WAIT: begin
                if (wcnt == '0) st_n = ST_REFRESH;
                else            wcnt_n = wcnt - 1'b1;
            end
            ST_REFRESH: begin
                st_n   = ST_RECOVER;
                wcnt_n = TRFC_LOAD;
            end
            ST_RECOVER: begin
                if (wcnt == '0) st_n = (owed_nz && gnt) ? ST_REFRESH : ST_IDLE;
                else            wcnt_n = wcnt - 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            wcnt <= '0;
        end else begin
            st   <= st_n;
            wcnt <= wcnt_n;
        end
    end

    assign req   = (st != ST_IDLE);
    assign a10   = (st == ST_CLOSE);
    assign issue = (st == ST_REFRESH);

    always_comb begin
        unique case (st)
            ST_CLOSE:   cmd = CMD_PRECH;
            ST_REFRESH: cmd = CMD_AREF;
            default:    cmd = CMD_DESEL;
        endcase
    end

    // R3
    cmd_needs_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_DESEL) |-> gnt);

    // R6
    no_cmd_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_AREF) |=> (cmd == CMD_DESEL));

    // R7
    req_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> ($past(st) == ST_RECOVER));

    // R5
    close_then_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRECH) |=> (cmd == CMD_DESEL && req));

endmodule

// File: rtl/refresh_scheduler.sv
`timescale 1ns/1ps
module refresh_scheduler
    import rfs_pkg::*;
#(
    parameter longint unsigned CLK_PS    = 64'd8000,
    parameter longint unsigned ROWS      = 64'd8192,
    parameter longint unsigned WINDOW_PS = 64'd64_000_000_000,
    parameter longint unsigned TRFC_PS   = 64'd75000,
    parameter longint unsigned TRP_PS    = 64'd20000,
    parameter int              MAX_OWED  = 8,
    parameter int              BANKS     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BANKS-1:0] bank_open,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             dram_cs_n,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic             dram_a10
);
    localparam int INTERVAL_CYC = interval_cycles(WINDOW_PS, ROWS, CLK_PS);
    localparam int TRFC_CYC     = at_least_two(ceil_cycles(TRFC_PS, CLK_PS));
    localparam int TRP_CYC      = at_least_two(ceil_cycles(TRP_PS, CLK_PS));

    logic      tick;
    logic      owed_nz;
    logic      issue;
    dram_cmd_t cmd;

    rfs_interval #(.PERIOD(INTERVAL_CYC)) u_interval (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rfs_owed #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk     (clk),
        .rst     (rst),
        .add     (tick),
        .take    (issue),
        .owed_nz (owed_nz)
    );

    rfs_fsm #(.BANKS(BANKS), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .owed_nz   (owed_nz),
        .gnt       (ref_gnt),
        .bank_open (bank_open),
        .req       (ref_req),
        .cmd       (cmd),
        .a10       (dram_a10),
        .issue     (issue)
    );

    assign dram_cs_n  = cmd.cs_n;
    assign dram_ras_n = cmd.ras_n;
    assign dram_cas_n = cmd.cas_n;
    assign dram_we_n  = cmd.we_n;

endmodule

// File: tb/refresh_scheduler_tb.sv
`timescale 1ns/1ps
module refresh_scheduler_tb;

    localparam int EXP_INT   = 976;
    localparam int EXP_INT4K = 1953;
    localparam int TRFC_C    = 10;
    localparam int TRP_C     = 3;
    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_PRE   = 4'b0010;
    localparam logic [3:0] C_REF   = 4'b0001;

    typedef struct packed {
        logic [3:0] mask;
        int         hold;
        logic       exp_pre;
        int         exp_refs;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{mask: 4'b0000, hold: 0,               exp_pre: 1'b0, exp_refs: 1},
        '{mask: 4'b0001, hold: 3,               exp_pre: 1'b1, exp_refs: 1},
        '{mask: 4'b1010, hold: 20,              exp_pre: 1'b1, exp_refs: 1},
        '{mask: 4'b0000, hold: EXP_INT + 40,    exp_pre: 1'b0, exp_refs: 2},
        '{mask: 4'b1111, hold: 2*EXP_INT + 50,  exp_pre: 1'b1, exp_refs: 3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] bank_open = '0;
    logic ref_gnt = 1'b0;
    logic ref_req, cs_n, ras_n, cas_n, we_n, a10;
    logic req4k, cs4k, ras4k, cas4k, we4k, a104k;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    refresh_scheduler u_dut (
        .clk(clk), .rst(rst), .bank_open(bank_open), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .dram_cs_n(cs_n), .dram_ras_n(ras_n),
        .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_a10(a10)
    );

    refresh_scheduler #(.ROWS(64'd4096)) u_dut4k (
        .clk(clk), .rst(rst), .bank_open(4'b0000), .ref_gnt(1'b0),
        .ref_req(req4k), .dram_cs_n(cs4k), .dram_ras_n(ras4k),
        .dram_cas_n(cas4k), .dram_we_n(we4k), .dram_a10(a104k)
    );

    wire [3:0] cmdv = {cs_n, ras_n, cas_n, we_n};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_req();
        while (!ref_req) @(negedge clk);
    endtask

    task automatic serve(input logic [3:0] mask, input int hold,
                         input bit exp_pre, input int exp_refs, input string tag);
        int n_pre, n_ref, pre_cyc, last_ref, g, bad_idle, bad_cmd, bad_gap, a10_bad, end_cyc, first_ref;
        n_pre = 0; n_ref = 0; pre_cyc = -1; last_ref = -1; first_ref = -1;
        bad_idle = 0; bad_cmd = 0; bad_gap = 0; a10_bad = 0; end_cyc = -1;
        wait_req();
        bank_open = mask;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (cmdv != C_DESEL) bad_idle++;
        end
        ref_gnt = 1'b1;
        g = cyc;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!ref_req) begin
                end_cyc = cyc;
                break;
            end
            if (cmdv == C_PRE) begin
                n_pre++;
                pre_cyc = cyc;
                if (n_ref != 0) bad_cmd++;
                if (!a10) a10_bad++;
            end else if (cmdv == C_REF) begin
                if (a10) a10_bad++;
                if (n_ref == 0) first_ref = cyc;
                else if (cyc - last_ref != TRFC_C) bad_gap++;
                last_ref = cyc;
                n_ref++;
            end else if (cmdv != C_DESEL) begin
                bad_cmd++;
            end else if (a10) begin
                a10_bad++;
            end
        end
        ref_gnt = 1'b0;
        bank_open = '0;
        // R3 no command while waiting for grant
        check(bad_idle == 0, {"R3 ", tag}, bad_idle, 0);
        // R4 precharge-all present only when a bank is open, A10 high with it
        check(n_pre == int'(exp_pre), {"R4 ", tag}, n_pre, int'(exp_pre));
        check(a10_bad == 0, {"R4 a10 ", tag}, a10_bad, 0);
        // R5 refresh placement
        if (exp_pre) check(first_ref - pre_cyc == TRP_C, {"R5 trp ", tag}, first_ref - pre_cyc, TRP_C);
        else         check(first_ref - g == 1, {"R5 direct ", tag}, first_ref - g, 1);
        // R6 only precharge/refresh encodings, none after refresh
        check(bad_cmd == 0, {"R6 ", tag}, bad_cmd, 0);
        // R8 count and spacing of owed refreshes
        check(n_ref == exp_refs, {"R8 count ", tag}, n_ref, exp_refs);
        check(bad_gap == 0, {"R8 gap ", tag}, bad_gap, 0);
        // R7 request released TRFC after last refresh
        check(end_cyc - last_ref == TRFC_C, {"R7 ", tag}, end_cyc - last_ref, TRFC_C);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        while (cyc != EXP_INT4K || rst) @(negedge clk);
        // R2 4096-row device interval
        check(req4k == 1'b0, "R2 before", int'(req4k), 0);
        @(negedge clk);
        check(req4k == 1'b1, "R2 at", int'(req4k), 1);
    end

    initial begin
        int first;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(ref_req == 1'b0, "R9 req", int'(ref_req), 0);
        check(cmdv == C_DESEL, "R9 cmd", int'(cmdv), int'(C_DESEL));
        check(a10 == 1'b0, "R9 a10", int'(a10), 0);
        rst = 1'b0;
        wait_req();
        first = cyc;
        // R1 first request after one interval
        check(first == EXP_INT + 1, "R1 first", first, EXP_INT + 1);
        foreach (VECS[k]) begin
            serve(VECS[k].mask, VECS[k].hold, VECS[k].exp_pre, VECS[k].exp_refs,
                  $sformatf("vec%0d", k));
        end
        // R8 saturation at eight owed refreshes
        serve(4'b0000, 9*EXP_INT + 30, 1'b0, 8, "saturate");
        // R8 open banks with burst: one precharge then two refreshes
        serve(4'b0100, EXP_INT + 10, 1'b1, 2, "burst_pre");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule